// File: doc/BRIEF.md
# Serial Link Self-Test Pixel Checker

This block sits at the receive end of a serial pixel link and checks a self-test run. The transmitter sends a pseudo-random PRBS-7 word on every pixel clock. While a test-enable input is held high, the block keeps a local copy of that sequence and compares each received word against it. Words count only while a lock input says the recovered data is valid. The first locked word aligns the local reference, so no handshake is needed.

Each errored pixel drives the pass output low for the clock-low half of one pixel period. Runs of errors therefore show up as separate pulses that external logic can count. A saturating counter keeps the number of errored pixels and can be read at any time. Once the enable drops, the pass output stops pulsing and holds a single verdict for the whole run. That verdict is also pulled low if lock was lost during the run. The length of the run, and with it the error-rate bound it proves, is set only by how long the enable is held.

Top module: `link_bist_checker`

## Requirements
- R1: After reset, pass_o is low and err_cnt_o is zero.
- R2: The clock edge at which bist_en_i is first sampled high opens a test window and clears err_cnt_o to zero, the error history and the lock-lost history.
- R3: A pixel sampled while lock_i is low is never compared and never counted. The first pixel sampled with lock_i high in a window only seeds the reference and is never counted as an error.
- R4: The reference follows x^7 + x^6 + 1, one bit per step, so each bit is the XOR of the bits seven and six steps earlier. A word holds PIX_W consecutive bits, with bit PIX_W-1 the earliest. After a seed word, the reference state is that word's bits 6:0.
- R5: In a window, the edge that samples a matching pixel makes pass_o high for the whole following clock period.
- R6: In a window, the edge that samples a mismatching pixel makes pass_o high while clk is high and low while clk is low in the following period. Consecutive errors give one falling edge of pass_o each, all falling while clk is low.
- R7: The reference advances from its own state and not from the received data, so a good pixel after an errored one still matches.
- R8: err_cnt_o adds one per mismatching pixel in a window and saturates at 2^CNT_W-1.
- R9: From the edge that samples bist_en_i low after a window, pass_o holds high if the window had no error and no lock loss, and low otherwise. Pixels arriving while bist_en_i is low change neither pass_o nor err_cnt_o.
- R10: If lock_i falls after a locked pixel in a window, checking pauses and a sticky lock-lost condition forces the final verdict low. The next locked pixel re-seeds the reference and checking resumes with no false errors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bist_en_i | input | 1 | Test window enable, high for the run length |
| lock_i | input | 1 | Receiver lock, qualifies the pixel data |
| pix_i | input | PIX_W | Received pixel word |
| pass_o | output | 1 | Per-pixel pass pulse in a window, held verdict after it |
| err_cnt_o | output | CNT_W | Saturating count of errored pixels |

## Verification
The assertions assume that every input is stable around the rising clock edge and that PIX_W is at least seven. They also assume the seed word has a nonzero low seven bits, because an all-zero PRBS state never leaves zero. The bench changes inputs just after the falling edge only, and it takes every word from one continuous nonzero PRBS-7 stream. Any word the design seeds from is therefore a valid, nonzero point of the sequence. Corrupted words are never placed where a seed occurs.

// File: rtl/link_bist_pkg.sv
package link_bist_pkg;

    localparam int PRBS_ORDER = 7;

    typedef struct packed {
        logic en_prev;    // enable sampled at the previous edge
        logic win;        // window open (drives pulse mode of pass_o)
        logic seeded;     // reference aligned to the stream
        logic lock_seen;  // a locked pixel arrived in this window
        logic lock_lost;  // lock dropped after lock_seen
        logic any_err;    // at least one mismatch in this window
        logic err_flag;   // last sampled pixel mismatched
        logic result;     // held verdict after the window
    } ctl_state_t;

endpackage

// File: rtl/link_bist_prbs_ref.sv
module link_bist_prbs_ref
    import link_bist_pkg::*;
#(
    parameter int PIX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             seed_i,
    input  logic             adv_i,
    input  logic [PIX_W-1:0] seed_word_i,
    output logic [PIX_W-1:0] ref_o
);

    logic [PIX_W-1:0] ref_d, ref_q;
    logic [PIX_W-1:0] gen_word;

    // Unroll PIX_W serial steps of x^7 + x^6 + 1, earliest bit in the MSB.
    always_comb begin
        logic [PRBS_ORDER-1:0] st;
        logic                  nb;
        st = seed_i ? seed_word_i[PRBS_ORDER-1:0] : ref_q[PRBS_ORDER-1:0];
        gen_word = '0;
        for (int i = PIX_W - 1; i >= 0; i--) begin
            nb          = st[6] ^ st[5];
            gen_word[i] = nb;
            st          = {st[5:0], nb};
        end
        ref_d = (seed_i || adv_i) ? gen_word : ref_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ref_q <= '0;
        else        ref_q <= ref_d;
    end

    assign ref_o = ref_q;

    initial begin
        if (PIX_W < PRBS_ORDER) $error("PIX_W must cover the PRBS state");
    end

    // R4: seeding and advancing are separate events
    p_seed_adv_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !(seed_i && adv_i));

    // R4: a nonzero state never collapses to the all-zero state
    p_state_nonzero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv_i && ref_q[PRBS_ORDER-1:0] != '0) |=> ref_q[PRBS_ORDER-1:0] != '0);

endmodule

// File: rtl/link_bist_err_counter.sv
module link_bist_err_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)                          cnt_d = '0;
        else if (inc_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr_i) |=> cnt_q == CNT_MAX);

    p_inc_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1);

endmodule

// File: rtl/link_bist_pass_shaper.sv
module link_bist_pass_shaper (
    input  logic clk,
    input  logic win_i,
    input  logic err_i,
    input  logic result_i,
    output logic pass_o
);

    // Low only while clk is low in a period that follows an errored pixel.
    always_comb begin
        if (win_i) pass_o = !(err_i && !clk);
        else       pass_o = result_i;
    end

endmodule

// File: rtl/link_bist_checker.sv
module link_bist_checker
    import link_bist_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bist_en_i,
    input  logic             lock_i,
    input  logic [PIX_W-1:0] pix_i,
    output logic             pass_o,
    output logic [CNT_W-1:0] err_cnt_o
);

    ctl_state_t       st_d, st_q;
    logic             seed, adv, inc, clr;
    logic [PIX_W-1:0] ref_word;
    logic             en_rise, en_fall;

    assign en_rise = bist_en_i && !st_q.en_prev;
    assign en_fall = !bist_en_i && st_q.en_prev;

    always_comb begin
        logic seeded_b, seen_b;
        st_d          = st_q;
        st_d.en_prev  = bist_en_i;
        st_d.win      = bist_en_i;
        st_d.err_flag = 1'b0;
        seed = 1'b0;
        adv  = 1'b0;
        inc  = 1'b0;
        clr  = 1'b0;
        seeded_b = st_q.seeded;
        seen_b   = st_q.lock_seen;
        if (en_rise) begin
            clr            = 1'b1;
            seeded_b       = 1'b0;
            seen_b         = 1'b0;
            st_d.lock_lost = 1'b0;
            st_d.any_err   = 1'b0;
        end
        st_d.seeded    = seeded_b;
        st_d.lock_seen = seen_b;
        if (bist_en_i) begin
            if (lock_i) begin
                st_d.lock_seen = 1'b1;
                if (!seeded_b) begin
                    seed        = 1'b1;
                    st_d.seeded = 1'b1;
                end else begin
                    adv = 1'b1;
                    if (pix_i != ref_word) begin
                        st_d.err_flag = 1'b1;
                        st_d.any_err  = 1'b1;
                        inc           = 1'b1;
                    end
                end
            end else begin
                st_d.seeded = 1'b0;
                if (seen_b) st_d.lock_lost = 1'b1;
            end
        end
        if (en_fall) st_d.result = !st_q.any_err && !st_q.lock_lost;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    link_bist_prbs_ref #(.PIX_W(PIX_W)) u_ref (
        .clk         (clk),
        .rst_n       (rst_n),
        .seed_i      (seed),
        .adv_i       (adv),
        .seed_word_i (pix_i),
        .ref_o       (ref_word)
    );

    link_bist_err_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (clr),
        .inc_i (inc),
        .cnt_o (err_cnt_o)
    );

    link_bist_pass_shaper u_shape (
        .clk      (clk),
        .win_i    (st_q.win),
        .err_i    (st_q.err_flag),
        .result_i (st_q.result),
        .pass_o   (pass_o)
    );

    p_open_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bist_en_i && !st_q.en_prev) |=> err_cnt_o == '0);

    p_unlocked_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_i |=> !st_q.err_flag);

    p_idle_cnt_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bist_en_i |=> err_cnt_o == $past(err_cnt_o));

    p_idle_result_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!bist_en_i && !st_q.en_prev) |=> $stable(st_q.result));

    p_lost_forces_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!bist_en_i && st_q.en_prev && st_q.lock_lost) |=> !pass_o);

endmodule

// File: tb/link_bist_checker_bench.sv
module link_bist_checker_bench;

    localparam int PIX_W = 12;
    localparam int CNT_W = 16;
    localparam int NVEC  = 25;

    // en, lock, bad, pass in high phase, pass in low phase, count after edge
    typedef struct packed {
        logic        en;
        logic        lock;
        logic        bad;
        logic        hi;
        logic        lo;
        logic [15:0] cnt;
    } vec_t;

    localparam vec_t TBL [NVEC] = '{
        {5'b10011, 16'd0},  // 0  open, unlocked (R2, R3)
        {5'b10111, 16'd0},  // 1  corrupt word while unlocked is ignored (R3)
        {5'b11011, 16'd0},  // 2  first locked pixel seeds (R3)
        {5'b11011, 16'd0},  // 3  match (R4, R5)
        {5'b11110, 16'd1},  // 4  single error (R6)
        {5'b11011, 16'd1},  // 5  alignment kept after error (R7)
        {5'b11110, 16'd2},  // 6  burst (R6)
        {5'b11110, 16'd3},  // 7
        {5'b11110, 16'd4},  // 8
        {5'b11011, 16'd4},  // 9
        {5'b01000, 16'd4},  // 10 close, verdict low (R9)
        {5'b01100, 16'd4},  // 11 error after window ignored (R9)
        {5'b11011, 16'd0},  // 12 reopen clears count, seeds (R2)
        {5'b11011, 16'd0},  // 13
        {5'b11011, 16'd0},  // 14
        {5'b11011, 16'd0},  // 15
        {5'b01011, 16'd0},  // 16 clean close, verdict high (R9)
        {5'b01111, 16'd0},  // 17 late error keeps verdict high (R9)
        {5'b11011, 16'd0},  // 18 open and seed
        {5'b11011, 16'd0},  // 19
        {5'b10011, 16'd0},  // 20 lock lost (R10)
        {5'b10111, 16'd0},  // 21 unlocked garbage ignored (R10)
        {5'b11011, 16'd0},  // 22 relock re-seeds (R10)
        {5'b11011, 16'd0},  // 23 no false error after relock (R10)
        {5'b01000, 16'd0}   // 24 close, lock loss forces verdict low (R10)
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bist_en_i = 1'b0;
    logic             lock_i = 1'b0;
    logic [PIX_W-1:0] pix_i = '0;
    logic             pass_o;
    logic [CNT_W-1:0] err_cnt_o;

    int   n_chk = 0;
    int   n_fail = 0;
    int   pulses = 0;
    logic done = 1'b0;
    logic [6:0] hist = 7'b1011001;

    always #4 clk = !clk;

    link_bist_checker #(.PIX_W(PIX_W), .CNT_W(CNT_W)) u_link_bist_checker (
        .clk       (clk),
        .rst_n     (rst_n),
        .bist_en_i (bist_en_i),
        .lock_i    (lock_i),
        .pix_i     (pix_i),
        .pass_o    (pass_o),
        .err_cnt_o (err_cnt_o)
    );

    // Count error pulses: falls of pass_o while clk is low.
    always @(negedge pass_o) if (clk === 1'b0) pulses++;

    // Serial PRBS-7 stream, earliest bit packed in the MSB (R4).
    function automatic logic [PIX_W-1:0] next_word();
        logic [PIX_W-1:0] w;
        logic             b;
        for (int i = 0; i < PIX_W; i++) begin
            b    = hist[6] ^ hist[5];
            hist = {hist[5:0], b};
            w    = {w[PIX_W-2:0], b};
        end
        return w;
    endfunction

    task automatic drive(input logic en, input logic lk, input logic bad);
        logic [PIX_W-1:0] w;
        w = next_word();
        bist_en_i = en;
        lock_i    = lk;
        pix_i     = bad ? (w ^ {{(PIX_W-1){1'b0}}, 1'b1}) : w;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // Reset state (R1)
        repeat (3) @(negedge clk);
        #1;
        check("R1 pass", {31'd0, pass_o}, 32'd0);
        check("R1 cnt", {16'd0, err_cnt_o}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        drive(1'b0, 1'b0, 1'b0);
        @(negedge clk);
        #1;
        pulses = 0;

        // Table walk
        for (int i = 0; i < NVEC; i++) begin
            string tag;
            drive(TBL[i].en, TBL[i].lock, TBL[i].bad);
            tag = !TBL[i].en ? "R9" : (!TBL[i].lo ? "R6" : "R5");
            @(posedge clk);
            #1;
            check({tag, " pass high phase"}, {31'd0, pass_o}, {31'd0, TBL[i].hi});
            @(negedge clk);
            #1;
            check({tag, " pass low phase"}, {31'd0, pass_o}, {31'd0, TBL[i].lo});
            check("R8 count", {16'd0, err_cnt_o}, {16'd0, TBL[i].cnt});
        end
        check("R6 pulse count", pulses, 32'd4);

        // Saturation (R8)
        drive(1'b1, 1'b1, 1'b0);
        for (int k = 0; k < 65540; k++) begin
            @(negedge clk);
            #1;
            drive(1'b1, 1'b1, 1'b1);
        end
        @(negedge clk);
        #1;
        check("R8 saturated", {16'd0, err_cnt_o}, 32'd65535);
        drive(1'b0, 1'b1, 1'b0);
        @(negedge clk);
        #1;
        check("R8 held at max", {16'd0, err_cnt_o}, 32'd65535);
        check("R9 verdict low", {31'd0, pass_o}, 32'd0);
        drive(1'b0, 1'b1, 1'b1);
        @(negedge clk);
        #1;
        check("R9 count frozen", {16'd0, err_cnt_o}, 32'd65535);

        // Reopen clears the counter (R2)
        drive(1'b1, 1'b1, 1'b0);
        @(negedge clk);
        #1;
        check("R2 cleared", {16'd0, err_cnt_o}, 32'd0);
        drive(1'b1, 1'b1, 1'b0);
        @(negedge clk);
        #1;
        check("R7 match after reopen", {31'd0, pass_o}, 32'd1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule